// File: doc/BRIEF.md
# Byte-wide SPI port with master and slave modes

This block links a simple host register bus to a four-wire SPI link. One mode bit selects its role. As master, the block drives SCK from a programmable divider and shifts one byte out on MOSI, MSB first, whenever the host writes the data register. It captures MISO in the last system clock of each bit. As slave, the block oversamples the external SCK, MOSI and active-low NSS with the system clock. It shifts a byte in from MOSI and presents a preloaded byte on MISO.

Clock polarity and clock phase are programmable, and they apply in both roles. A single status/configuration register reports several conditions: a busy flag, a filtered slave-select flag, the raw NSS level, and two slave-only empty flags for the shift register and the receive buffer. Both empty flags read 1 in master mode. A filtered rise of NSS aborts a slave transfer that has not finished, and the bit count starts again from zero.

Top module: `spi_port`

## Requirements
- R1: After reset the status register (address 0) reads 0x07 while NSS is held high, and the divider register (address 2) reads 0. Status bit positions: 7 busy, 6 master enable, 5 clock phase, 4 clock polarity, 3 slave selected, 2 raw NSS, 1 shift-register empty, 0 receive-buffer empty. Address 1 is the data register.
- R2: Only status bits 6, 5 and 4 take host writes; writing 0xFF and then 0x00 with NSS high and nothing pending reads back 0x77 and then 0x07.
- R3: In master mode a data write starts a transfer, busy reads 1 until the last bit ends, and SCK rests at the clock polarity level whenever the port is idle.
- R4: In master mode every SCK half period lasts divider+1 system clocks, and busy stays high for exactly 16*(divider+1) clocks.
- R5: The master shifts the byte out on MOSI MSB first and captures MISO in the last system clock of each bit; the captured byte is read back from address 1.
- R6: With clock phase 0 data is valid at the first SCK edge of each bit and changes on the second; with clock phase 1 it changes on the first edge and is valid at the second; this holds for both polarities.
- R7: In slave mode MOSI is taken on the data-valid SCK edge; busy reads 1 during the byte; after eight bits receive-buffer empty reads 0, the byte reads back at address 1, and the read sets receive-buffer empty to 1.
- R8: In slave mode a data write loads the transmit byte into the shift register (shift-register empty goes 0). The byte leaves on MISO MSB first, and shift-register empty returns to 1 when the byte ends with no new byte waiting.
- R9: The slave-selected bit follows NSS low only after three consistent filtered samples, so a low pulse of two system clocks is ignored; the raw NSS bit shows the pin level with no delay.
- R10: In slave mode a filtered NSS rise during a transfer clears busy, leaves the receive buffer untouched, and resets the bit count so that the next selection receives a whole byte.
- R11: In master mode the shift-register-empty and receive-buffer-empty bits read 1 even when a slave byte is still unread.
- R12: A data write in master mode while a transfer is in progress is ignored: the ongoing byte and its timing do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (clears receive-buffer full on address 1) |
| addr | input | 2 | Register address: 0 status/config, 1 data, 2 divider |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational on addr |
| sck_o | output | 1 | SCK driven in master mode |
| sck_oe | output | 1 | SCK output enable (master mode) |
| sck_i | input | 1 | SCK received in slave mode |
| mosi_o | output | 1 | MOSI driven in master mode |
| mosi_oe | output | 1 | MOSI output enable (master mode) |
| mosi_i | input | 1 | MOSI received in slave mode |
| miso_o | output | 1 | MISO driven in slave mode |
| miso_oe | output | 1 | MISO output enable (slave mode while selected) |
| miso_i | input | 1 | MISO received in master mode |
| nss_i | input | 1 | Active-low slave select |

## Verification
A wrong master half-period count changes the spacing between SCK edges at the very next edge and the busy length at the end of the byte. Both appear within one transfer. A corrupted shift or bit counter shows as a wrong MOSI bit at the next data-valid edge, or as a wrong byte at address 1 once the transfer ends. A slave bit counter that abort fails to clear corrupts the next full byte. A filter that changes state too early makes a two-clock NSS pulse appear in the slave-selected bit within about six clocks.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;

  typedef struct packed {
    logic busy;
    logic master;
    logic cpha;
    logic cpol;
    logic slv_sel;
    logic nss_raw;
    logic sr_empty;
    logic rx_empty;
  } status_t;

  // System clocks in one SCK half period for a divider setting.
  function automatic int unsigned half_cycles(input int unsigned div);
    return div + 1;
  endfunction

  // SCK level from polarity, phase, activity and the half of the bit.
  function automatic logic sck_level(input logic cpol, input logic cpha,
                                     input logic active, input logic half);
    return cpol ^ (active & (cpha ? ~half : half));
  endfunction

  // True when an edge of the given kind is the data-valid edge.
  function automatic logic edge_is_sample(input logic cpha, input logic leading);
    return cpha ? ~leading : leading;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_nss_filter.sv
module spi_nss_filter #(
  parameter int TAPS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  output logic            filt,
  output logic [TAPS-1:0] hist
);
  logic filt_d;

  always_comb begin
    if (&hist)       filt_d = 1'b1;
    else if (~|hist) filt_d = 1'b0;
    else             filt_d = filt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '1;
      filt <= 1'b1;
    end else begin
      hist <= {hist[TAPS-2:0], din};
      filt <= filt_d;
    end
  end
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  div,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              miso_i,
  output logic              busy,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              half_tick,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DIV_W-1:0]  cnt_q;
  logic              half_q;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] txs_q;
  logic [DATA_W-1:0] rxs_q;
  logic              bit_end;

  assign half_tick = busy && (cnt_q == div);
  assign bit_end   = half_tick && half_q;
  assign done      = bit_end && (bit_q == LAST);
  assign rx_byte   = {rxs_q[DATA_W-2:0], miso_i};
  assign sck_o     = sck_level(cpol, cpha, busy, half_q);
  assign mosi_o    = txs_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      half_q <= 1'b0;
      bit_q  <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt_q  <= '0;
      half_q <= 1'b0;
      bit_q  <= '0;
      txs_q  <= tx_byte;
    end else if (busy) begin
      if (half_tick) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (bit_end) begin
        rxs_q <= {rxs_q[DATA_W-2:0], miso_i};
        txs_q <= {txs_q[DATA_W-2:0], 1'b0};
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sel,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              busy,
  output logic              miso_o,
  output logic              start,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_prev;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] txs_q;
  logic [DATA_W-1:0] rxs_q;
  logic              act, edge_seen, leading, sample_kind, sample, shift;

  assign act         = enable && sel;
  assign edge_seen   = sck_s != sck_prev;
  assign leading     = sck_s != cpol;
  assign sample_kind = edge_is_sample(cpha, leading);
  assign start       = act && edge_seen && leading && !busy;
  assign sample      = act && edge_seen && sample_kind && (busy || start);
  assign shift       = act && edge_seen && !sample_kind && busy;
  assign done        = sample && (bit_q == LAST);
  assign rx_byte     = {rxs_q[DATA_W-2:0], mosi_s};
  assign miso_o      = txs_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      bit_q <= '0;
      rxs_q <= '0;
    end else if (!act) begin
      busy  <= 1'b0;
      bit_q <= '0;
    end else begin
      if (start) busy <= 1'b1;
      if (sample) begin
        rxs_q <= rx_byte;
        if (bit_q == LAST) begin
          busy  <= 1'b0;
          bit_q <= '0;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     txs_q <= '0;
    else if (load)  txs_q <= tx_byte;
    else if (shift) txs_q <= {txs_q[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              miso_i,
  input  logic              nss_i
);
  // Host register state
  logic              cfg_master, cfg_cpha, cfg_cpol;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_buf, rx_buf;
  logic              tx_full, rx_valid, sr_empty_q;

  // Decoded host events
  logic wr_cfg, wr_data, wr_div, rd_data;
  assign wr_cfg  = wr_en && (addr == ADDR_CFG);
  assign wr_data = wr_en && (addr == ADDR_DATA);
  assign wr_div  = wr_en && (addr == ADDR_DIV);
  assign rd_data = rd_en && (addr == ADDR_DATA);

  // Pin conditioning
  logic nss_s, sck_s, mosi_s, nss_filt, slv_sel;
  logic [FILT_TAPS-1:0] nss_hist;

  spi_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nss_sync (
    .clk(clk), .rst_n(rst_n), .d(nss_i), .q(nss_s)
  );

  spi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_i, mosi_i}), .q({sck_s, mosi_s})
  );

  spi_nss_filter #(.TAPS(FILT_TAPS)) u_nss_filter (
    .clk(clk), .rst_n(rst_n), .din(nss_s), .filt(nss_filt), .hist(nss_hist)
  );

  assign slv_sel = ~nss_filt;

  // Master engine
  logic              m_start, m_busy, m_sck, m_mosi, m_half_tick, m_done;
  logic [DATA_W-1:0] m_rx_byte;
  assign m_start = wr_data && cfg_master && !m_busy;

  spi_master_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_master (
    .clk(clk), .rst_n(rst_n), .start(m_start), .tx_byte(wdata), .div(div_q),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .miso_i(miso_i), .busy(m_busy),
    .sck_o(m_sck), .mosi_o(m_mosi), .half_tick(m_half_tick), .done(m_done),
    .rx_byte(m_rx_byte)
  );

  // Slave engine
  logic              s_load, s_busy, s_miso, s_start, s_done;
  logic [DATA_W-1:0] s_rx_byte;
  assign s_load = tx_full && !s_busy && !cfg_master;

  spi_slave_engine #(.DATA_W(DATA_W)) u_slave (
    .clk(clk), .rst_n(rst_n), .enable(!cfg_master), .sel(slv_sel),
    .sck_s(sck_s), .mosi_s(mosi_s), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .load(s_load), .tx_byte(tx_buf), .busy(s_busy), .miso_o(s_miso),
    .start(s_start), .done(s_done), .rx_byte(s_rx_byte)
  );

  // Configuration and divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_master <= 1'b0;
      cfg_cpha   <= 1'b0;
      cfg_cpol   <= 1'b0;
      div_q      <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_master <= wdata[6];
        cfg_cpha   <= wdata[5];
        cfg_cpol   <= wdata[4];
      end
      if (wr_div) div_q <= wdata[DIV_W-1:0];
    end
  end

  // Transmit buffer and shift-register-empty flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf     <= '0;
      tx_full    <= 1'b0;
      sr_empty_q <= 1'b1;
    end else begin
      if (s_load) tx_full <= 1'b0;
      if (wr_data && !cfg_master) begin
        tx_buf  <= wdata;
        tx_full <= 1'b1;
      end
      if (s_load || s_start)       sr_empty_q <= 1'b0;
      else if (s_done && !tx_full) sr_empty_q <= 1'b1;
    end
  end

  // Receive buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf   <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (m_done) rx_buf <= m_rx_byte;
      if (s_done) begin
        rx_buf   <= s_rx_byte;
        rx_valid <= 1'b1;
      end else if (rd_data) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // Status and read mux
  status_t status_q;
  logic    st_sr_empty, st_rx_empty, st_busy;
  assign st_busy     = cfg_master ? m_busy : s_busy;
  assign st_sr_empty = cfg_master | sr_empty_q;
  assign st_rx_empty = cfg_master | ~rx_valid;

  always_comb begin
    status_q.busy     = st_busy;
    status_q.master   = cfg_master;
    status_q.cpha     = cfg_cpha;
    status_q.cpol     = cfg_cpol;
    status_q.slv_sel  = slv_sel;
    status_q.nss_raw  = nss_i;
    status_q.sr_empty = st_sr_empty;
    status_q.rx_empty = st_rx_empty;
  end

  always_comb begin
    case (addr)
      ADDR_CFG:  rdata = DATA_W'(status_q);
      ADDR_DATA: rdata = rx_buf;
      ADDR_DIV:  rdata = DATA_W'(div_q);
      default:   rdata = '0;
    endcase
  end

  // Pins
  assign sck_o   = cfg_master ? m_sck : cfg_cpol;
  assign sck_oe  = cfg_master;
  assign mosi_o  = m_mosi;
  assign mosi_oe = cfg_master;
  assign miso_o  = s_miso;
  assign miso_oe = !cfg_master && slv_sel;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int TAPS = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_master,
  input logic            cfg_cpol,
  input logic            m_busy,
  input logic            sck_o,
  input logic            m_half_tick,
  input logic            nss_filt,
  input logic [TAPS-1:0] nss_hist,
  input logic            s_busy,
  input logic            slv_sel,
  input logic            rx_valid,
  input logic            s_done,
  input logic            wr_data,
  input logic            st_sr_empty,
  input logic            st_rx_empty
);
  // R11
  master_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master |-> (st_sr_empty && st_rx_empty));

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !m_busy) |-> (sck_o == cfg_cpol));

  // R3
  master_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_busy) |-> $past(wr_data && cfg_master));

  // R4
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && m_busy && $past(m_busy) && $stable(cfg_cpol) && (sck_o != $past(sck_o)))
      |-> $past(m_half_tick));

  // R9
  filter_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nss_filt != $past(nss_filt)) |-> ($past(nss_hist) == {TAPS{nss_filt}}));

  // R10
  slave_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && !slv_sel) |=> !s_busy);

  // R7
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(s_done));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
  .m_busy(m_busy), .sck_o(sck_o), .m_half_tick(m_half_tick),
  .nss_filt(nss_filt), .nss_hist(nss_hist), .s_busy(s_busy),
  .slv_sel(slv_sel), .rx_valid(rx_valid), .s_done(s_done),
  .wr_data(wr_data), .st_sr_empty(st_sr_empty), .st_rx_empty(st_rx_empty)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHP        = 8;
  localparam logic [1:0] A_CFG = 2'd0, A_DATA = 2'd1, A_DIV = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, nss_i = 1'b1;

  int checks = 0;
  int errors = 0;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .nss_i(nss_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int xfer_len(input int div);
    return 2 * 8 * (div + 1);
  endfunction

  function automatic logic [7:0] cfg_word(input bit master, input bit cpha, input bit cpol);
    return {1'b0, master, cpha, cpol, 4'b0000};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic master_xfer(input bit cpol, input bit cpha, input int div,
                             input logic [7:0] tx, input logic [7:0] mb, input bit inject);
    logic [7:0] got, rx;
    logic prev, lead;
    int clocks, last, leads, trails, bad, nchg;
    got = 0; clocks = 0; last = 0; leads = 0; trails = 0; bad = 0; nchg = 0;
    wr(A_CFG, cfg_word(1'b1, cpha, cpol));
    wr(A_DIV, div[7:0]);
    miso_i = cpha ? 1'b0 : mb[7];
    @(negedge clk);
    check("R3 idle sck level", sck_o, cpol);
    addr = A_DATA; wdata = tx; wr_en = 1'b1; prev = sck_o;
    @(negedge clk);
    forever begin
      addr = A_CFG; wr_en = 1'b0;
      #1;
      if (!rdata[7] || clocks > 20000) break;
      clocks++;
      if (sck_o !== prev) begin
        nchg++;
        if (nchg > 1 && (clocks - last) != div + 1) bad++;
        last = clocks;
        lead = (sck_o != cpol);
        if (lead != cpha) begin
          got = {got[6:0], mosi_o};
        end else if (cpha) begin
          if (leads < 8) miso_i = mb[7 - leads];
          leads++;
        end else begin
          trails++;
          if (trails < 8) miso_i = mb[7 - trails];
        end
        prev = sck_o;
      end
      if (inject && clocks == 3) begin
        addr = A_DATA; wdata = ~tx; wr_en = 1'b1;
      end
      @(negedge clk);
    end
    check("R4 busy length", clocks, xfer_len(div));
    check("R4 half period spacing errors", bad, 0);
    if (inject) check("R12 byte unchanged by write while busy", got, tx);
    else        check("R6 MOSI byte at data-valid edges", got, tx);
    check("R3 sck back at idle level", sck_o, cpol);
    rd(A_DATA, rx);
    check("R5 captured MISO byte", rx, mb);
  endtask

  task automatic slave_xfer(input bit cpol, input bit cpha, input logic [7:0] mb,
                            input logic [7:0] tx, input int nb, input bit keep);
    logic [7:0] got, st, rx;
    got = 0;
    wr(A_CFG, cfg_word(1'b0, cpha, cpol));
    sck_i = cpol; mosi_i = 1'b0;
    wr(A_DATA, tx);
    wait_clk(4);
    peek(A_CFG, st);
    check("R8 shift register loaded", st[1], 0);
    nss_i = 1'b0;
    wait_clk(12);
    peek(A_CFG, st);
    check("R9 selected after filter", st[3], 1);
    for (int k = 0; k < nb; k++) begin
      if (!cpha) begin
        mosi_i = mb[7 - k];
        wait_clk(SHP);
        got = {got[6:0], miso_o};
        sck_i = ~cpol;
        wait_clk(SHP);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        mosi_i = mb[7 - k];
        wait_clk(SHP);
        got = {got[6:0], miso_o};
        sck_i = cpol;
        wait_clk(SHP);
      end
      if (k == 2) begin
        peek(A_CFG, st);
        check("R7 busy during slave byte", st[7], 1);
      end
    end
    if (nb < 8) begin
      nss_i = 1'b1;
      wait_clk(12);
      peek(A_CFG, st);
      check("R10 busy cleared by abort", st[7], 0);
      check("R10 receive buffer untouched", st[0], 1);
      return;
    end
    wait_clk(SHP);
    peek(A_CFG, st);
    check("R7 busy low after byte", st[7], 0);
    check("R7 receive buffer full", st[0], 0);
    check("R8 shift register empty after byte", st[1], 1);
    check("R8 MISO byte", got, tx);
    if (!keep) begin
      rd(A_DATA, rx);
      check("R7 received byte", rx, mb);
      peek(A_CFG, st);
      check("R7 empty after read", st[0], 1);
    end
    nss_i = 1'b1;
    wait_clk(12);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] st, v;
    void'($urandom(32'd4417));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);

    peek(A_CFG, st);
    check("R1 status reset", st, 8'h07);
    peek(A_DIV, v);
    check("R1 divider reset", v, 8'h00);

    wr(A_CFG, 8'hFF);
    peek(A_CFG, st);
    check("R2 write all ones", st, 8'h77);
    wr(A_CFG, 8'h00);
    peek(A_CFG, st);
    check("R2 write zeros", st, 8'h07);

    // R9 glitch rejection and raw pin readback
    @(negedge clk);
    nss_i = 1'b0;
    peek(A_CFG, st);
    check("R9 raw NSS immediate", st[2], 0);
    check("R9 filtered not yet", st[3], 0);
    @(negedge clk);
    @(negedge clk);
    nss_i = 1'b1;
    wait_clk(10);
    peek(A_CFG, st);
    check("R9 two-clock glitch ignored", st[3], 0);

    // Master directed corners
    master_xfer(1'b0, 1'b0, 0,   8'hA5, 8'h3C, 1'b0);
    master_xfer(1'b1, 1'b1, 255, 8'h81, 8'h7E, 1'b0);
    master_xfer(1'b0, 1'b1, 2,   8'h5A, 8'hC3, 1'b1);
    peek(A_CFG, st);
    check("R11 master empty flags", st[1:0], 2'b11);
    for (int i = 0; i < 6; i++) begin
      master_xfer(1'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
                  8'($urandom), 8'($urandom), 1'b0);
    end

    // Slave directed corners
    slave_xfer(1'b0, 1'b0, 8'hC6, 8'h39, 8, 1'b0);
    slave_xfer(1'b1, 1'b1, 8'h0F, 8'hF1, 8, 1'b0);
    slave_xfer(1'b0, 1'b0, 8'hFF, 8'h12, 3, 1'b0);
    slave_xfer(1'b0, 1'b0, 8'h96, 8'h4B, 8, 1'b1);
    rd(A_DATA, v);
    check("R10 full byte after abort", v, 8'h96);

    // R11 unread slave byte hidden in master mode
    slave_xfer(1'b1, 1'b0, 8'h2D, 8'hE7, 8, 1'b1);
    wr(A_CFG, cfg_word(1'b1, 1'b0, 1'b0));
    peek(A_CFG, st);
    check("R11 flags read 1 in master mode", st[1:0], 2'b11);
    wr(A_CFG, cfg_word(1'b0, 1'b0, 1'b0));
    peek(A_CFG, st);
    check("R11 unread byte visible in slave mode", st[0], 0);
    rd(A_DATA, v);
    check("R7 unread byte kept", v, 8'h2D);

    for (int i = 0; i < 4; i++) begin
      slave_xfer(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 8, 1'b0);
    end

    summary();
    $finish;
  end
endmodule